// File: doc/BRIEF.md
# Programmable-timing SPI frame master

This block is the transfer engine of an SPI master. A single start strobe latches a full command and runs one frame. The frame proceeds in this order: the chosen select line goes active, a programmable setup interval passes, the data bits are shifted, a programmable hold interval passes, the select line is released, and a programmable idle gap elapses. The result word then appears together with a one-cycle done pulse. The serial clock is SPI mode 0: SCK idles low and MISO is sampled on the rising edge. Data moves MSB first.

Every timing value is counted in SCK periods. One period P is `2 * BASE_HALF << rateDiv` system clocks, where `rateDiv` is 0 to 3 and selects divide-by-1, 2, 4 or 8. Each of the three delays has its own enable and a 3-bit count n. With the enable set the delay is n+1 periods; with the enable clear it is one period. The engine can leave select asserted after a frame so that the next frame continues the same access. It also sets what MOSI shows while no frame is active, and can run in transmit-only mode, where nothing is received.

Top module: `spi_frame_master`

## Requirements
- R1: After reset, busy and done are low, SCK is low, MOSI is low, rxData is zero and all four select pins are high.
- R2: lenCode 4'hF shifts 16 bits and 4'h3 shifts 32 bits. Every other code, including 4'h4 to 4'h7 and unlisted values, shifts 8 bits. The number of SCK rising edges equals that length.
- R3: MOSI sends the low `length` bits of txData, MSB first, and is stable at each SCK rising edge. SCK is low whenever no bits are being shifted.
- R4: When txOnly is 0, rxData at done holds the bits sampled from MISO on the SCK rising edges, first bit highest, right-justified, with the upper bits zero.
- R5: When txOnly is 1, MISO is ignored and rxData keeps the value it had before the frame.
- R6: The interval between consecutive SCK rising edges is P = 2·BASE_HALF·2^rateDiv clocks.
- R7: The first SCK rising edge comes S·P clocks after select asserts. S = setupCnt+1 when setupEn is 1, else S = 1.
- R8: Select negates H·P clocks after the last SCK falling edge. H = holdCnt+1 when holdEn is 1, else H = 1.
- R9: done pulses for exactly one cycle G·P+2 clocks after select negates. G = gapCnt+1 when gapEn is 1, else G = 1. busy falls in the following cycle.
- R10: During a frame, only the select pin numbered selIdx (0 to 3) is active. It is high when selActiveHigh is 1 and low when it is 0. All other pins stay at their inactive level.
- R11: With keepSel = 1, the select pin stays active after done and through the next frame's start. A later frame with keepSel = 0 releases it.
- R12: Outside a frame, MOSI equals idleLevel when idleFixEn is 1; otherwise it holds the last data bit sent.
- R13: A start while busy is high is ignored. The running frame's data is unchanged and only one done is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame; accepted only when idle |
| txData | input | 32 | Transmit word, right-justified |
| lenCode | input | 4 | Frame length code |
| rateDiv | input | 2 | Bit-rate division code |
| selIdx | input | 2 | Select line to drive |
| selActiveHigh | input | 1 | Select polarity, 1 = active high |
| keepSel | input | 1 | Keep select asserted after the frame |
| setupEn | input | 1 | Use setupCnt for the setup delay |
| setupCnt | input | 3 | Setup delay periods minus one |
| holdEn | input | 1 | Use holdCnt for the hold delay |
| holdCnt | input | 3 | Hold delay periods minus one |
| gapEn | input | 1 | Use gapCnt for the idle gap |
| gapCnt | input | 3 | Gap periods minus one |
| idleFixEn | input | 1 | Drive idleLevel on MOSI between frames |
| idleLevel | input | 1 | Fixed MOSI level between frames |
| txOnly | input | 1 | Transmit-only mode, MISO not captured |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rxData | output | 32 | Received word |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssel | output | 4 | Select lines |

## Verification
Start is sampled on the rising edge after the bench raises it. Select is active from the next cycle, and the first SCK rise follows exactly S·P cycles later. The bench samples every output at the falling edge and logs the cycle number of each select edge, SCK edge and done pulse. The setup, hold, gap and period checks therefore compare differences of logged cycles with S·P, H·P, G·P+2 and P. The idle MOSI level and the select pin levels are read one falling edge after done, when the engine is back in idle. The slave model changes MISO at the falling edge that follows each SCK fall, so every bit is stable well before the rising edge that samples it.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  localparam int WORD_W = 32;
  localparam int BITS_W = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_SHIFT, ST_HOLD, ST_GAP, ST_DONE
  } spimState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // latch a new command word
    logic sample;  // SCK rising edge: capture MISO
    logic shift;   // SCK falling edge with bits left: advance MOSI
    logic active;  // select window (setup, shift, hold)
  } spimStrobe_t;

  function automatic logic [BITS_W-1:0] frameBits(input logic [3:0] code);
    case (code)
      4'hF:    return BITS_W'(16);
      4'h3:    return BITS_W'(32);
      default: return BITS_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/spim_ctrl.sv
`timescale 1ns/1ps
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int BASE_HALF = 1,
  parameter int SEL_N     = 4,
  parameter int DLY_W     = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [3:0]               lenCode,
  input  logic [1:0]               rateDiv,
  input  logic [$clog2(SEL_N)-1:0] selIdx,
  input  logic                     selActiveHigh,
  input  logic                     keepSel,
  input  logic                     setupEn,
  input  logic [DLY_W-1:0]         setupCnt,
  input  logic                     holdEn,
  input  logic [DLY_W-1:0]         holdCnt,
  input  logic                     gapEn,
  input  logic [DLY_W-1:0]         gapCnt,
  output spimStrobe_t              strobe,
  output logic                     busy,
  output logic                     done,
  output logic                     sck,
  output logic [SEL_N-1:0]         ssel
);
  localparam int SEL_W   = $clog2(SEL_N);
  localparam int HALF_MX = BASE_HALF * 8;
  localparam int PER_MX  = 2 * HALF_MX;
  localparam int CNT_MX  = PER_MX * (1 << DLY_W) + 2;
  localparam int CNT_W   = $clog2(CNT_MX + 1);

  spimState_e         state;
  logic [CNT_W-1:0]   cnt;
  logic [BITS_W-1:0]  bitCnt;
  logic [CNT_W-1:0]   halfQ, periodQ, holdCycQ, gapCycQ;
  logic               keepQ, selOn, polQ;
  logic [SEL_W-1:0]   lineQ;

  logic [CNT_W-1:0]   halfNew, periodNew, setupCyc;

  function automatic logic [CNT_W-1:0] delayCycles(input logic en,
      input logic [DLY_W-1:0] n, input logic [CNT_W-1:0] per);
    logic [CNT_W-1:0] mult;
    mult = en ? (CNT_W'(n) + CNT_W'(1)) : CNT_W'(1);
    return CNT_W'(mult * per);
  endfunction

  always_comb begin
    halfNew   = CNT_W'(BASE_HALF) << rateDiv;
    periodNew = halfNew << 1;
    setupCyc  = delayCycles(setupEn, setupCnt, periodNew);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitCnt   <= '0;
      halfQ    <= CNT_W'(BASE_HALF);
      periodQ  <= CNT_W'(2 * BASE_HALF);
      holdCycQ <= '0;
      gapCycQ  <= '0;
      keepQ    <= 1'b0;
      selOn    <= 1'b0;
      polQ     <= 1'b0;
      lineQ    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_SETUP;
          // rising edge lands at S*P: first half-period of bit 0 counts
          cnt      <= setupCyc - halfNew - CNT_W'(1);
          bitCnt   <= frameBits(lenCode) - BITS_W'(1);
          halfQ    <= halfNew;
          periodQ  <= periodNew;
          holdCycQ <= delayCycles(holdEn, holdCnt, periodNew);
          gapCycQ  <= delayCycles(gapEn, gapCnt, periodNew) + CNT_W'(2);
          keepQ    <= keepSel;
          polQ     <= selActiveHigh;
          lineQ    <= selIdx;
          selOn    <= 1'b1;
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            state <= ST_SHIFT;
            cnt   <= periodQ - CNT_W'(1);
          end else cnt <= cnt - CNT_W'(1);
        end
        ST_SHIFT: begin
          if (cnt == '0) begin
            if (bitCnt == '0) begin
              state <= ST_HOLD;
              cnt   <= holdCycQ - CNT_W'(1);
            end else begin
              bitCnt <= bitCnt - BITS_W'(1);
              cnt    <= periodQ - CNT_W'(1);
            end
          end else cnt <= cnt - CNT_W'(1);
        end
        ST_HOLD: begin
          if (cnt == '0) begin
            state <= ST_GAP;
            cnt   <= gapCycQ - CNT_W'(1);
            selOn <= keepQ;
          end else cnt <= cnt - CNT_W'(1);
        end
        ST_GAP: begin
          if (cnt == '0) state <= ST_DONE;
          else cnt <= cnt - CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy          = (state != ST_IDLE);
    done          = (state == ST_DONE);
    sck           = (state == ST_SHIFT) && (cnt < halfQ);
    strobe.load   = (state == ST_IDLE) && start;
    strobe.sample = (state == ST_SHIFT) && (cnt == halfQ);
    strobe.shift  = (state == ST_SHIFT) && (cnt == '0) && (bitCnt != '0);
    strobe.active = (state == ST_SETUP) || (state == ST_SHIFT) ||
                    (state == ST_HOLD);
  end

  for (genvar g = 0; g < SEL_N; g++) begin : g_sel
    logic lineOn;
    assign lineOn = selOn && (lineQ == SEL_W'(g));
    assign ssel[g] = polQ ? lineOn : !lineOn;
  end

  // R13: busy never drops before the done pulse
  a_r13_busy_until_done: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
  // R13: command state frozen while busy
  a_r13_cmd_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(lineQ) && $stable(polQ) && $stable(periodQ)));
  // R9: done lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R10: SCK only toggles with select asserted
  a_r10_sck_in_select: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sck) |-> selOn);
  // R2: bit counter within the longest frame
  a_r2_bitcnt_range: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT) |-> (bitCnt < BITS_W'(WORD_W)));
endmodule

// File: rtl/spim_dpath.sv
`timescale 1ns/1ps
module spim_dpath
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  spimStrobe_t       strobe,
  input  logic [WORD_W-1:0] txData,
  input  logic [3:0]        lenCode,
  input  logic              txOnly,
  input  logic              idleFixEn,
  input  logic              idleLevel,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rxData
);
  logic [WORD_W-1:0] txShift, rxShift;
  logic              duplexQ, fixQ, levelQ;
  logic [BITS_W-1:0] padBits;

  assign padBits = BITS_W'(WORD_W) - frameBits(lenCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      duplexQ <= 1'b0;
      fixQ    <= 1'b0;
      levelQ  <= 1'b0;
    end else if (strobe.load) begin
      txShift <= txData << padBits;
      duplexQ <= !txOnly;
      fixQ    <= idleFixEn;
      levelQ  <= idleLevel;
      if (!txOnly) rxShift <= '0;
    end else begin
      if (strobe.sample && duplexQ) rxShift <= {rxShift[WORD_W-2:0], miso};
      if (strobe.shift) txShift <= {txShift[WORD_W-2:0], 1'b0};
    end
  end

  // last bit stays at the MSB since the final bit is never shifted away
  assign mosi   = (!strobe.active && fixQ) ? levelQ : txShift[WORD_W-1];
  assign rxData = rxShift;

  // R5: transmit-only frames leave the receive word alone
  a_r5_txonly_rx_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!duplexQ && !strobe.load) |=> $stable(rxShift));
  // R12: MOSI does not move between frames
  a_r12_idle_mosi_steady: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.active && !strobe.load) |=> (strobe.active || $stable(mosi)));
  // R4: sampling only inside the select window
  a_r4_sample_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sample |-> strobe.active);
endmodule

// File: rtl/spi_frame_master.sv
`timescale 1ns/1ps
module spi_frame_master
  import spim_pkg::*;
#(
  parameter int BASE_HALF = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] txData,
  input  logic [3:0]  lenCode,
  input  logic [1:0]  rateDiv,
  input  logic [1:0]  selIdx,
  input  logic        selActiveHigh,
  input  logic        keepSel,
  input  logic        setupEn,
  input  logic [2:0]  setupCnt,
  input  logic        holdEn,
  input  logic [2:0]  holdCnt,
  input  logic        gapEn,
  input  logic [2:0]  gapCnt,
  input  logic        idleFixEn,
  input  logic        idleLevel,
  input  logic        txOnly,
  output logic        busy,
  output logic        done,
  output logic [31:0] rxData,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  ssel
);
  spimStrobe_t strobe;

  spim_ctrl #(.BASE_HALF(BASE_HALF), .SEL_N(4), .DLY_W(3)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .lenCode(lenCode),
    .rateDiv(rateDiv), .selIdx(selIdx), .selActiveHigh(selActiveHigh),
    .keepSel(keepSel), .setupEn(setupEn), .setupCnt(setupCnt),
    .holdEn(holdEn), .holdCnt(holdCnt), .gapEn(gapEn), .gapCnt(gapCnt),
    .strobe(strobe), .busy(busy), .done(done), .sck(sck), .ssel(ssel)
  );

  spim_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txData(txData),
    .lenCode(lenCode), .txOnly(txOnly), .idleFixEn(idleFixEn),
    .idleLevel(idleLevel), .miso(miso), .mosi(mosi), .rxData(rxData)
  );
endmodule

// File: tb/test_spi_frame_master.sv
`timescale 1ns/1ps
module test_spi_frame_master;
  logic        clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [31:0] txData = '0;
  logic [3:0]  lenCode = '0;
  logic [1:0]  rateDiv = '0, selIdx = '0;
  logic        selActiveHigh = 0, keepSel = 0, setupEn = 0, holdEn = 0, gapEn = 0;
  logic [2:0]  setupCnt = '0, holdCnt = '0, gapCnt = '0;
  logic        idleFixEn = 0, idleLevel = 0, txOnly = 0, miso = 0;
  logic        busy, done, sck, mosi;
  logic [31:0] rxData;
  logic [3:0]  ssel;

  spi_frame_master i_spi_frame_master (.*);

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor / slave model state
  int curLine = 0, curBits = 8, sIdx = 0;
  logic curPol = 0;
  logic [31:0] slaveWord = '0, mosiCap = '0, rxAtDone = '0;
  logic actPrev = 0, sckPrev = 0, otherHit = 0;
  logic [3:0] sselAtRise = '0;
  int tAssert, tNegate, tFirst, tSecond, tLastFall, tDone;
  int riseCnt = 0, doneCnt = 0;

  always @(negedge clk) begin
    logic act;
    act = busy && (curPol ? ssel[curLine] : !ssel[curLine]);
    for (int l = 0; l < 4; l++)
      if (l != curLine && busy && (curPol ? ssel[l] : !ssel[l])) otherHit = 1;
    if (act && !actPrev) begin
      tAssert = cyc;
      miso = slaveWord[curBits-1];
      sIdx = curBits - 2;
    end
    if (!act && actPrev) tNegate = cyc;
    if (sck && !sckPrev) begin
      if (riseCnt == 0) begin tFirst = cyc; sselAtRise = ssel; end
      if (riseCnt == 1) tSecond = cyc;
      riseCnt++;
      mosiCap = {mosiCap[30:0], mosi};
    end
    if (!sck && sckPrev) begin
      tLastFall = cyc;
      if (sIdx >= 0) begin miso = slaveWord[sIdx]; sIdx--; end
    end
    if (done) begin doneCnt++; tDone = cyc; rxAtDone = rxData; end
    actPrev = act;
    sckPrev = sck;
  end

  task automatic setCfg(input logic [3:0] len, input logic [1:0] dv,
      input int line, input logic pol, input logic keep,
      input logic sE, input logic [2:0] sC, input logic hE, input logic [2:0] hC,
      input logic gE, input logic [2:0] gC, input logic fix, input logic lvl,
      input logic txo, input logic [31:0] tx, input logic [31:0] slave);
    lenCode = len; rateDiv = dv; selIdx = 2'(line); selActiveHigh = pol;
    keepSel = keep; setupEn = sE; setupCnt = sC; holdEn = hE; holdCnt = hC;
    gapEn = gE; gapCnt = gC; idleFixEn = fix; idleLevel = lvl; txOnly = txo;
    txData = tx; slaveWord = slave; curLine = line; curPol = pol;
    curBits = (len == 4'hF) ? 16 : (len == 4'h3) ? 32 : 8;
  endtask

  task automatic runFrame();
    int d0;
    @(negedge clk);
    riseCnt = 0; mosiCap = '0; otherHit = 0;
    tAssert = -1; tNegate = -1; tFirst = -1; tSecond = -1; tLastFall = -1; tDone = -1;
    d0 = doneCnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (doneCnt == d0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 sck", sck, 0);
    chk("R1 mosi", mosi, 0);
    chk("R1 rxData", rxData, 0);
    chk("R1 ssel", ssel, 4'hF);
  endtask

  task automatic t_byteBasic();
    setCfg(4'h7, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'hA5, 32'h3C);
    runFrame();
    chk("R2 len7 rises", riseCnt, 8);
    chk("R3 mosi bits", mosiCap, 32'hA5);
    chk("R4 rx", rxAtDone, 32'h3C);
    chk("R6 period d0", tSecond - tFirst, 2);
    chk("R7 setup default", tFirst - tAssert, 2);
    chk("R8 hold default", tNegate - tLastFall, 2);
    chk("R9 gap default", tDone - tNegate, 4);
    chk("R9 busy low after done", busy, 0);
    chk("R10 other lines idle", otherHit, 0);
    chk("R10 active-low line0", sselAtRise, 4'b1110);
    chk("R10 released", ssel, 4'hF);
    chk("R3 sck idle low", sck, 0);
    chk("R12 mosi holds last bit", mosi, 1);
  endtask

  task automatic t_word16();
    setCfg(4'hF, 2'd1, 1, 0, 0, 1, 3'd2, 1, 3'd4, 1, 3'd7, 1, 0, 0,
           32'hBEEF, 32'h1234);
    runFrame();
    chk("R2 len F rises", riseCnt, 16);
    chk("R3 mosi bits 16", mosiCap, 32'hBEEF);
    chk("R4 rx 16", rxAtDone, 32'h1234);
    chk("R6 period d1", tSecond - tFirst, 4);
    chk("R7 setup 3 periods", tFirst - tAssert, 12);
    chk("R8 hold 5 periods", tNegate - tLastFall, 20);
    chk("R9 gap 8 periods", tDone - tNegate, 34);
    chk("R10 active-low line1", sselAtRise, 4'b1101);
    chk("R12 mosi fixed low", mosi, 0);
  endtask

  task automatic t_word32TxOnly();
    setCfg(4'h3, 2'd3, 3, 1, 0, 1, 3'd0, 0, 0, 0, 0, 0, 0, 1,
           32'hDEADBEEF, 32'h0F0F0F0F);
    runFrame();
    chk("R2 len 3 rises", riseCnt, 32);
    chk("R3 mosi bits 32", mosiCap, 32'hDEADBEEF);
    chk("R5 rx kept in tx-only", rxAtDone, 32'h1234);
    chk("R6 period d3", tSecond - tFirst, 16);
    chk("R7 setup 1 period", tFirst - tAssert, 16);
    chk("R8 hold d3", tNegate - tLastFall, 16);
    chk("R9 gap d3", tDone - tNegate, 18);
    chk("R10 active-high line3", sselAtRise, 4'b1000);
    chk("R10 active-high released", ssel, 4'b0000);
    chk("R10 other lines idle hi", otherHit, 0);
    chk("R12 mosi last bit", mosi, 1);
  endtask

  task automatic t_unlistedLen();
    setCfg(4'h0, 2'd2, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0,
           32'hFFFFFF5A, 32'hABCDEFC3);
    runFrame();
    chk("R2 unlisted code 8 bits", riseCnt, 8);
    chk("R3 only low byte sent", mosiCap, 32'h5A);
    chk("R4 rx upper zero", rxAtDone, 32'hC3);
    chk("R6 period d2", tSecond - tFirst, 8);
  endtask

  task automatic t_keep();
    logic broken;
    setCfg(4'h4, 2'd0, 2, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h81, 32'h7E);
    runFrame();
    chk("R2 len4 rises", riseCnt, 8);
    chk("R4 rx keep frame", rxAtDone, 32'h7E);
    broken = 0;
    for (int i = 0; i < 6; i++) begin
      if (ssel !== 4'b1011) broken = 1;
      @(negedge clk);
    end
    chk("R11 select kept after done", broken, 0);
    setCfg(4'h4, 2'd0, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h42, 32'h00);
    riseCnt = 0; mosiCap = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (riseCnt == 0) begin
      if (ssel[2] !== 1'b0) broken = 1;
      @(negedge clk);
    end
    chk("R11 select held into next frame", broken, 0);
    while (busy) @(negedge clk);
    chk("R3 mosi kept frame", mosiCap, 32'h42);
    chk("R11 select released", ssel, 4'hF);
  endtask

  task automatic t_startWhileBusy();
    int d0;
    setCfg(4'h7, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h3C, 32'h96);
    @(negedge clk);
    riseCnt = 0; mosiCap = '0;
    d0 = doneCnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk("R13 busy mid frame", busy, 1);
    txData = 32'hFF;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (doneCnt == d0) @(negedge clk);
    repeat (40) @(negedge clk);
    chk("R13 data unchanged", mosiCap, 32'h3C);
    chk("R13 single done", doneCnt - d0, 1);
    chk("R13 idle after frame", busy, 0);
    chk("R4 rx busy test", rxData, 32'h96);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_byteBasic();
    t_word16();
    t_word32TxOnly();
    t_unlistedLen();
    t_keep();
    t_startWhileBusy();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule